// File: doc/BRIEF.md
# Event Counter Bank with Set/Clear Bitmaps

This block is the counting core of a performance monitor for an address translation unit. It holds a bank of event counters, each advanced by a single-cycle qualified pulse from an external filter stage. Software reaches the bank through a small valid/ready register bus with 32-bit and 64-bit accesses. It can preload each counter with a starting value, such as half of full scale, so that an overflow occurs after a chosen number of events. A counter that rolls over latches a pending overflow bit, and a level interrupt follows from it when permitted.

Per-counter enables, interrupt enables and overflow flags live in bitmaps that are never written directly. Each bitmap has one address where a one bit sets the matching flag and another where a one bit clears it; zero bits do nothing. Reading either address returns the bitmap. A read-only capability word reports the counter count, the counter width and some feature flags. Counter slots are 4 bytes apart when counters are at most 32 bits wide and 8 bytes apart otherwise. Per-counter event-type and stream-match words are plain storage, driven out to the filter stage.

Top module: `pmu_ctr_bank`

## Requirements
- R1: After reset, every counter, enable bitmap, overflow bitmap, the global run bit and the interrupt control bit read as zero, and irq_o is low.
- R2: Counter n sits at byte offset n*4 when CTR_W <= 32 and at n*8 otherwise. A 64-bit access at an 8-byte slot moves the full counter, truncated to CTR_W. A 32-bit access at slot+4 reaches bits [63:32] of that slot.
- R3: A counter advances by one at the clock edge that samples its evt_i bit high, but only while bit 0 of 0xE04 (global run) is 1 and its counter-enable bit is 1. Otherwise it holds.
- R4: Counter enables are set by writing ones to 0xC00 and cleared by writing ones to 0xC20. Interrupt enables are set at 0xC40 and cleared at 0xC60. Zero bits leave flags unchanged, and reading either address of a pair returns the bitmap.
- R5: A counting step from all ones to zero sets that counter's overflow bit at the same clock edge.
- R6: The overflow bitmap reads at 0xCC0 and at 0xC80. Writing ones to 0xC80 clears bits and writing ones to 0xCC0 sets bits. A wrap coinciding with a clear of the same bit leaves the bit set.
- R7: irq_o is high exactly when bit 0 of 0xE50 is 1 and some counter has both its overflow bit and its interrupt-enable bit set.
- R8: Software can write a counter value. A write and a counting step on the same counter in the same cycle leave the written value.
- R9: The word at 0xE00 is read-only and reports: NUM_CTR-1 in bits [5:0], CTR_W-1 in bits [13:8], the relocated-page flag in bit 20, the message-signalled-interrupt flag in bit 21, and the global-filter flag in bit 23.
- R10: The 64-bit words at 0xE20 and 0xE28 return bits [63:0] and [127:64] of the EVT_SUPPORT parameter, a bitmap with one bit per event code.
- R11: Event-type word n at 0x400+4n and stream-match word n at 0xA00+4n are 32-bit read/write storage. They drive evtype_o[32n+31:32n] and smr_o[32n+31:32n].
- R12: Counter, event-type and stream-match indices at or above NUM_CTR read as zero and ignore writes. Bitmap bits at or above NUM_CTR read as zero.
- R13: Every accepted request gets rsp_valid_o one cycle later. A read returns the addressed word there, with 32-bit reads in bits [31:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wide_i | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr_i | input | ADDR_W | Byte address, 4-byte aligned |
| req_wdata_i | input | 64 | Write data; 32-bit writes use bits [31:0] |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_rdata_o | output | 64 | Read data |
| evt_i | input | NUM_CTR | Qualified event pulses, one per counter |
| irq_o | output | 1 | Level overflow interrupt |
| evtype_o | output | NUM_CTR*32 | Event-type words to the filter stage |
| smr_o | output | NUM_CTR*32 | Stream-match words to the filter stage |

## Verification
Writes take effect at the edge that accepts them, so register state and irq_o can be sampled on the falling edge after that edge. Read data appears on rsp_rdata_o one edge after acceptance, and rsp_valid_o is checked in the same falling-edge sample. An event pulse held for one cycle is counted at the following edge, and any wrap shows in the overflow bitmap from then on. The bench drives every request and pulse on a falling edge, releases it on the next falling edge, and checks results only at those release points.

// File: rtl/pmu_ctr_pkg.sv
package pmu_ctr_pkg;
  // doubleword (8-byte) indices of register groups
  localparam int DW_EVTYPE    = 'h400 >> 3;
  localparam int DW_SMR       = 'hA00 >> 3;
  localparam int DW_CNTEN_SET = 'hC00 >> 3;
  localparam int DW_CNTEN_CLR = 'hC20 >> 3;
  localparam int DW_INTEN_SET = 'hC40 >> 3;
  localparam int DW_INTEN_CLR = 'hC60 >> 3;
  localparam int DW_OVS_CLR   = 'hC80 >> 3;
  localparam int DW_OVS_SET   = 'hCC0 >> 3;
  localparam int DW_CFG_CTRL  = 'hE00 >> 3;
  localparam int DW_EVT_LO    = 'hE20 >> 3;
  localparam int DW_EVT_HI    = 'hE28 >> 3;
  localparam int DW_IRQ_CTRL  = 'hE50 >> 3;

  function automatic logic [31:0] cfg_word(input int n, input int w,
                                           input bit reloc, input bit msi,
                                           input bit gflt);
    logic [31:0] r;
    r       = '0;
    r[5:0]  = 6'(n - 1);
    r[13:8] = 6'(w - 1);
    r[20]   = reloc;
    r[21]   = msi;
    r[23]   = gflt;
    return r;
  endfunction
endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  // software write has priority over counting
  assign wrap_o = inc_i & ~wr_i & (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (wr_i)  cnt_o <= wdata_i;
    else if (inc_i) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/pmu_bitmap.sv
module pmu_bitmap #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/pmu_ctr_bank.sv
module pmu_ctr_bank
  import pmu_ctr_pkg::*;
#(
  parameter int           NUM_CTR     = 8,
  parameter int           CTR_W       = 40,
  parameter int           ADDR_W      = 12,
  parameter bit           HAS_RELOC   = 1'b0,
  parameter bit           HAS_MSI     = 1'b0,
  parameter bit           GLOBAL_FILT = 1'b0,
  parameter logic [127:0] EVT_SUPPORT = 128'hFF
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic                    req_wide_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [63:0]             req_wdata_i,
  output logic                    rsp_valid_o,
  output logic [63:0]             rsp_rdata_o,
  input  logic [NUM_CTR-1:0]      evt_i,
  output logic                    irq_o,
  output logic [NUM_CTR*32-1:0]   evtype_o,
  output logic [NUM_CTR*32-1:0]   smr_o
);
  localparam bit WIDE_CTR = CTR_W > 32;
  localparam int DW_W     = ADDR_W - 3;
  localparam logic [31:0] CFG_VAL =
    cfg_word(NUM_CTR, CTR_W, HAS_RELOC, HAS_MSI, GLOBAL_FILT);

  logic [DW_W-1:0] dw;
  logic            hi;
  logic            acc_ok, wr_en;
  logic [63:0]     wmask64, wdata64, rd64, rd_out;

  assign dw          = req_addr_i[ADDR_W-1:3];
  assign hi          = req_addr_i[2];
  assign acc_ok      = req_valid_i & (req_addr_i[1:0] == 2'b00);
  assign wr_en       = acc_ok & req_write_i;
  assign req_ready_o = 1'b1;

  // position 32-bit writes within the addressed doubleword
  always_comb begin
    if (req_wide_i) begin
      wmask64 = '1;
      wdata64 = req_wdata_i;
    end else if (hi) begin
      wmask64 = {32'hFFFF_FFFF, 32'h0};
      wdata64 = {req_wdata_i[31:0], 32'h0};
    end else begin
      wmask64 = {32'h0, 32'hFFFF_FFFF};
      wdata64 = {32'h0, req_wdata_i[31:0]};
    end
  end

  function automatic logic hit(input logic [DW_W-1:0] d, input int idx);
    return int'(d) == idx;
  endfunction

  // ---------------- bitmaps ----------------
  logic [NUM_CTR-1:0] cnten_set, cnten_clr, inten_set, inten_clr;
  logic [NUM_CTR-1:0] ovs_sw_set, ovs_clr, ovs_set;
  logic [NUM_CTR-1:0] cnten_q, inten_q, ovs_q, wrap_vec;

  assign cnten_set  = {NUM_CTR{wr_en & hit(dw, DW_CNTEN_SET)}} & NUM_CTR'(wdata64 & wmask64);
  assign cnten_clr  = {NUM_CTR{wr_en & hit(dw, DW_CNTEN_CLR)}} & NUM_CTR'(wdata64 & wmask64);
  assign inten_set  = {NUM_CTR{wr_en & hit(dw, DW_INTEN_SET)}} & NUM_CTR'(wdata64 & wmask64);
  assign inten_clr  = {NUM_CTR{wr_en & hit(dw, DW_INTEN_CLR)}} & NUM_CTR'(wdata64 & wmask64);
  assign ovs_sw_set = {NUM_CTR{wr_en & hit(dw, DW_OVS_SET)}}   & NUM_CTR'(wdata64 & wmask64);
  assign ovs_clr    = {NUM_CTR{wr_en & hit(dw, DW_OVS_CLR)}}   & NUM_CTR'(wdata64 & wmask64);
  assign ovs_set    = ovs_sw_set | wrap_vec;

  pmu_bitmap #(.N(NUM_CTR)) u_cnten (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(cnten_set), .clr_i(cnten_clr), .q_o(cnten_q));
  pmu_bitmap #(.N(NUM_CTR)) u_inten (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(inten_set), .clr_i(inten_clr), .q_o(inten_q));
  pmu_bitmap #(.N(NUM_CTR)) u_ovs (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ovs_set), .clr_i(ovs_clr), .q_o(ovs_q));

  // ---------------- global controls ----------------
  logic ctrl_en_q, irq_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_en_q <= 1'b0;
      irq_en_q  <= 1'b0;
    end else begin
      if (wr_en && hit(dw, DW_CFG_CTRL) && wmask64[32]) ctrl_en_q <= wdata64[32];
      if (wr_en && hit(dw, DW_IRQ_CTRL) && wmask64[0])  irq_en_q  <= wdata64[0];
    end
  end

  assign irq_o = irq_en_q & (|(ovs_q & inten_q));

  // ---------------- per-counter slices ----------------
  logic [CTR_W-1:0]         cnt_q  [NUM_CTR];
  logic [63:0]              ctr_rd [NUM_CTR];
  logic [63:0]              reg_rd [NUM_CTR];
  logic [31:0]              evtype_q [NUM_CTR];
  logic [31:0]              smr_q    [NUM_CTR];
  logic [NUM_CTR*CTR_W-1:0] cnt_flat;

  for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
    localparam int CDW   = WIDE_CTR ? n : n / 2;
    localparam int CHALF = WIDE_CTR ? 0 : n % 2;
    localparam int EDW   = DW_EVTYPE + n / 2;
    localparam int SDW   = DW_SMR + n / 2;
    localparam int RHALF = n % 2;

    logic             c_wr;
    logic [CTR_W-1:0] c_wval;

    if (WIDE_CTR) begin : g_wide
      logic [63:0] merged;
      assign merged = (64'(cnt_q[n]) & ~wmask64) | (wdata64 & wmask64);
      assign c_wr   = wr_en & hit(dw, CDW);
      assign c_wval = merged[CTR_W-1:0];
    end else begin : g_narrow
      assign c_wr   = wr_en & hit(dw, CDW) & wmask64[CHALF*32];
      assign c_wval = wdata64[CHALF*32 +: CTR_W];
    end

    pmu_counter #(.W(CTR_W)) u_ctr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (ctrl_en_q & cnten_q[n] & evt_i[n]),
      .wr_i    (c_wr),
      .wdata_i (c_wval),
      .cnt_o   (cnt_q[n]),
      .wrap_o  (wrap_vec[n])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evtype_q[n] <= '0;
        smr_q[n]    <= '0;
      end else begin
        if (wr_en && hit(dw, EDW) && wmask64[RHALF*32]) evtype_q[n] <= wdata64[RHALF*32 +: 32];
        if (wr_en && hit(dw, SDW) && wmask64[RHALF*32]) smr_q[n]    <= wdata64[RHALF*32 +: 32];
      end
    end

    assign ctr_rd[n] = hit(dw, CDW) ? (64'(cnt_q[n]) << (CHALF * 32)) : 64'h0;
    assign reg_rd[n] = (hit(dw, EDW) ? (64'(evtype_q[n]) << (RHALF * 32)) : 64'h0)
                     | (hit(dw, SDW) ? (64'(smr_q[n])    << (RHALF * 32)) : 64'h0);

    assign evtype_o[n*32 +: 32]        = evtype_q[n];
    assign smr_o[n*32 +: 32]           = smr_q[n];
    assign cnt_flat[n*CTR_W +: CTR_W]  = cnt_q[n];
  end

  // ---------------- read path ----------------
  always_comb begin
    rd64 = '0;
    for (int n = 0; n < NUM_CTR; n++) rd64 = rd64 | ctr_rd[n] | reg_rd[n];
    case (int'(dw))
      DW_CNTEN_SET, DW_CNTEN_CLR: rd64 = rd64 | 64'(cnten_q);
      DW_INTEN_SET, DW_INTEN_CLR: rd64 = rd64 | 64'(inten_q);
      DW_OVS_SET, DW_OVS_CLR:     rd64 = rd64 | 64'(ovs_q);
      DW_CFG_CTRL:                rd64 = rd64 | {31'h0, ctrl_en_q, CFG_VAL};
      DW_EVT_LO:                  rd64 = rd64 | EVT_SUPPORT[63:0];
      DW_EVT_HI:                  rd64 = rd64 | EVT_SUPPORT[127:64];
      DW_IRQ_CTRL:                rd64 = rd64 | 64'(irq_en_q);
      default: ;
    endcase
  end

  assign rd_out = req_wide_i ? rd64 : {32'h0, (hi ? rd64[63:32] : rd64[31:0])};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_rdata_o <= (acc_ok && !req_write_i) ? rd_out : 64'h0;
    end
  end
endmodule

// File: rtl/pmu_ctr_bank_chk.sv
module pmu_ctr_bank_chk #(
  parameter int N = 8,
  parameter int W = 40
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_valid_i,
  input logic         rsp_valid_o,
  input logic         irq_o,
  input logic         ctrl_en_q,
  input logic         irq_en_q,
  input logic [N-1:0] wrap_vec,
  input logic [N-1:0] ovs_q,
  input logic [N-1:0] inten_q,
  input logic [N-1:0] cnten_q,
  input logic [N-1:0] cnten_clr,
  input logic [N*W-1:0] cnt_flat
);
  AST_CNT_HOLD_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_en_q && !req_valid_i) |=> $stable(cnt_flat)); // R3

  AST_WRAP_SETS_OVS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|wrap_vec) |=> ((ovs_q & $past(wrap_vec)) == $past(wrap_vec))); // R5

  AST_CNTEN_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cnten_clr) |=> ((cnten_q & $past(cnten_clr)) == '0)); // R4

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_q |-> !irq_o); // R7

  AST_IRQ_NEEDS_INTEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inten_q == '0) |-> !irq_o); // R7

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o); // R13

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o); // R13
endmodule

bind pmu_ctr_bank pmu_ctr_bank_chk #(.N(NUM_CTR), .W(CTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .rsp_valid_o (rsp_valid_o),
  .irq_o       (irq_o),
  .ctrl_en_q   (ctrl_en_q),
  .irq_en_q    (irq_en_q),
  .wrap_vec    (wrap_vec),
  .ovs_q       (ovs_q),
  .inten_q     (inten_q),
  .cnten_q     (cnten_q),
  .cnten_clr   (cnten_clr),
  .cnt_flat    (cnt_flat)
);

// File: tb/pmu_ctr_bank_bench.sv
`timescale 1ns/1ps
module pmu_ctr_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;

  // instance A: 4 narrow counters of 8 bits
  logic        a_valid = 0, a_write = 0, a_wide = 0;
  logic [11:0] a_addr = '0;
  logic [63:0] a_wdata = '0;
  logic [3:0]  a_evt = '0;
  logic        a_ready, a_rsp_valid, a_irq;
  logic [63:0] a_rdata;
  logic [127:0] a_evtype, a_smr;

  pmu_ctr_bank #(
    .NUM_CTR(4), .CTR_W(8), .ADDR_W(12), .GLOBAL_FILT(1'b1),
    .EVT_SUPPORT({64'h1, 64'hFF})
  ) u_pmu_ctr_bank (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(a_valid), .req_ready_o(a_ready), .req_write_i(a_write),
    .req_wide_i(a_wide), .req_addr_i(a_addr), .req_wdata_i(a_wdata),
    .rsp_valid_o(a_rsp_valid), .rsp_rdata_o(a_rdata),
    .evt_i(a_evt), .irq_o(a_irq), .evtype_o(a_evtype), .smr_o(a_smr)
  );

  // instance B: 2 wide counters of 40 bits
  logic        b_valid = 0, b_write = 0, b_wide = 0;
  logic [11:0] b_addr = '0;
  logic [63:0] b_wdata = '0;
  logic [1:0]  b_evt = '0;
  logic        b_ready, b_rsp_valid, b_irq;
  logic [63:0] b_rdata;
  logic [63:0] b_evtype, b_smr;

  pmu_ctr_bank #(.NUM_CTR(2), .CTR_W(40), .ADDR_W(12)) u_pmu_ctr_bank_w (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(b_valid), .req_ready_o(b_ready), .req_write_i(b_write),
    .req_wide_i(b_wide), .req_addr_i(b_addr), .req_wdata_i(b_wdata),
    .rsp_valid_o(b_rsp_valid), .rsp_rdata_o(b_rdata),
    .evt_i(b_evt), .irq_o(b_irq), .evtype_o(b_evtype), .smr_o(b_smr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic a_wr(input logic [11:0] ad, input logic [63:0] d, input logic w);
    @(negedge clk);
    a_valid = 1; a_write = 1; a_wide = w; a_addr = ad; a_wdata = d;
    @(negedge clk);
    a_valid = 0; a_write = 0;
  endtask

  task automatic a_wr_evt(input logic [11:0] ad, input logic [63:0] d, input logic [3:0] m);
    @(negedge clk);
    a_valid = 1; a_write = 1; a_wide = 0; a_addr = ad; a_wdata = d; a_evt = m;
    @(negedge clk);
    a_valid = 0; a_write = 0; a_evt = '0;
  endtask

  task automatic a_rd(input logic [11:0] ad, input logic w, output logic [63:0] d);
    @(negedge clk);
    a_valid = 1; a_write = 0; a_wide = w; a_addr = ad;
    @(negedge clk);
    a_valid = 0;
    chk("R13 rsp_valid", 64'(a_rsp_valid), 64'h1);
    d = a_rdata;
  endtask

  task automatic a_pulse(input logic [3:0] m);
    @(negedge clk);
    a_evt = m;
    @(negedge clk);
    a_evt = '0;
  endtask

  task automatic b_wr(input logic [11:0] ad, input logic [63:0] d, input logic w);
    @(negedge clk);
    b_valid = 1; b_write = 1; b_wide = w; b_addr = ad; b_wdata = d;
    @(negedge clk);
    b_valid = 0; b_write = 0;
  endtask

  task automatic b_rd(input logic [11:0] ad, input logic w, output logic [63:0] d);
    @(negedge clk);
    b_valid = 1; b_write = 0; b_wide = w; b_addr = ad;
    @(negedge clk);
    b_valid = 0;
    d = b_rdata;
  endtask

  int exp_c [4];

  task automatic check_counters(input string req);
    logic [63:0] v;
    for (int n = 0; n < 4; n++) begin
      a_rd(12'(n * 4), 1'b0, v);
      chk(req, v, 64'(exp_c[n] & 255));
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog R13: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int n = 0; n < 4; n++) exp_c[n] = 0;
    check_counters("R1 counter reset");
    a_rd(12'hC00, 0, v); chk("R1 cnten reset", v, 0);
    a_rd(12'hC40, 0, v); chk("R1 inten reset", v, 0);
    a_rd(12'hCC0, 0, v); chk("R1 ovs reset", v, 0);
    a_rd(12'hE04, 0, v); chk("R1 run reset", v, 0);
    a_rd(12'hE50, 0, v); chk("R1 irq ctrl reset", v, 0);
    chk("R1 irq_o reset", 64'(a_irq), 0);

    // R9 capability word: 4 counters, 8 bits, global filter
    a_rd(12'hE00, 0, v); chk("R9 cfg word", v, 64'h0080_0703);
    b_rd(12'hE00, 0, v); chk("R9 cfg word wide", v, 64'h0000_2701);

    // R10 supported-event bitmap
    a_rd(12'hE20, 1, v); chk("R10 evt lo", v, 64'hFF);
    a_rd(12'hE28, 1, v); chk("R10 evt hi", v, 64'h1);
    a_rd(12'hE24, 0, v); chk("R10 evt lo upper half", v, 64'h0);

    // R4 set/clear enables
    a_wr(12'hC00, 64'h5, 0);
    a_rd(12'hC00, 0, v); chk("R4 cnten set view", v, 64'h5);
    a_rd(12'hC20, 0, v); chk("R4 cnten clr view", v, 64'h5);
    a_wr(12'hC20, 64'h1, 0);
    a_rd(12'hC00, 0, v); chk("R4 cnten clear bit0", v, 64'h4);
    a_wr(12'hC00, 64'hF0, 0);
    a_rd(12'hC00, 0, v); chk("R12 cnten bits above NUM_CTR", v, 64'h4);
    a_wr(12'hC00, 64'hF, 0);
    a_rd(12'hC20, 0, v); chk("R4 cnten all", v, 64'hF);

    // R3 no counting while run bit is 0
    a_pulse(4'hF);
    check_counters("R3 held while stopped");
    a_wr(12'hE04, 64'h1, 0);
    a_rd(12'hE04, 0, v); chk("R3 run bit readback", v, 64'h1);

    // R3 sweep all event patterns, all enabled
    for (int m = 0; m < 16; m++) begin
      a_pulse(4'(m));
      for (int n = 0; n < 4; n++) if (m[n]) exp_c[n]++;
    end
    check_counters("R3 sweep all enabled");

    // R3 sweep with counter 1 disabled
    a_wr(12'hC20, 64'h2, 0);
    for (int m = 0; m < 16; m++) begin
      a_pulse(4'(m));
      for (int n = 0; n < 4; n++) if (m[n] && n != 1) exp_c[n]++;
    end
    check_counters("R3 sweep partial enable");

    // R8 preload and write priority over counting
    a_wr(12'h008, 64'hFE, 0); exp_c[2] = 'hFE;
    a_wr_evt(12'h000, 64'h33, 4'h1); exp_c[0] = 'h33;
    check_counters("R8 preload and write wins");

    // R5 wrap sets overflow
    a_pulse(4'h4);
    a_rd(12'hCC0, 0, v); chk("R5 no ovs before wrap", v, 0);
    a_pulse(4'h4);
    a_rd(12'h008, 0, v); chk("R5 counter wrapped", v, 0);
    a_rd(12'hCC0, 0, v); chk("R5 ovs after wrap", v, 64'h4);
    a_rd(12'hC80, 0, v); chk("R6 ovs clear view", v, 64'h4);

    // R7 interrupt gating
    chk("R7 irq low without inten", 64'(a_irq), 0);
    a_wr(12'hC40, 64'h4, 0);
    chk("R7 irq low without irq ctrl", 64'(a_irq), 0);
    a_wr(12'hE50, 64'h1, 0);
    chk("R7 irq high", 64'(a_irq), 1);
    a_wr(12'hC80, 64'h4, 0);
    a_rd(12'hCC0, 0, v); chk("R6 ovs cleared", v, 0);
    chk("R7 irq drops on clear", 64'(a_irq), 0);

    // R6 wrap and clear in the same cycle: set wins
    a_wr(12'h008, 64'hFF, 0);
    a_wr_evt(12'hC80, 64'h4, 4'h4);
    a_rd(12'hCC0, 0, v); chk("R6 set beats clear", v, 64'h4);
    chk("R7 irq on pending ovs", 64'(a_irq), 1);
    a_wr(12'hC60, 64'h4, 0);
    chk("R7 irq off after inten clear", 64'(a_irq), 0);
    a_wr(12'hCC0, 64'h2, 0);
    a_rd(12'hCC0, 0, v); chk("R6 software set", v, 64'h6);
    a_wr(12'hCC0, 64'h30, 0);
    a_rd(12'hC80, 0, v); chk("R12 ovs bits above NUM_CTR", v, 64'h6);

    // R11 event-type and stream-match storage
    a_wr(12'h404, 64'h2000_0001, 0);
    chk("R11 evtype port", 64'(a_evtype[63:32]), 64'h2000_0001);
    a_rd(12'h400, 1, v); chk("R11 evtype doubleword", v, 64'h2000_0001_0000_0000);
    a_wr(12'hA0C, 64'h42, 0);
    chk("R11 smr port", 64'(a_smr[127:96]), 64'h42);
    a_rd(12'hA0C, 0, v); chk("R11 smr readback", v, 64'h42);

    // R12 unimplemented indices
    a_wr(12'h410, 64'h5, 0);
    a_rd(12'h410, 0, v); chk("R12 evtype idx4", v, 0);
    a_wr(12'h010, 64'h7, 0);
    a_rd(12'h010, 0, v); chk("R12 counter idx4", v, 0);
    exp_c[2] = 0;
    check_counters("R12 implemented counters untouched");

    // R2 wide counters, 8-byte stride
    b_wr(12'h008, 64'h0000_00AB_1234_5678, 1);
    b_rd(12'h008, 1, v); chk("R2 wide 64-bit read", v, 64'hAB_1234_5678);
    b_rd(12'h00C, 0, v); chk("R2 upper half read", v, 64'hAB);
    b_rd(12'h008, 0, v); chk("R2 lower half read", v, 64'h1234_5678);
    b_wr(12'h00C, 64'hCD, 0);
    b_rd(12'h008, 1, v); chk("R2 upper half write", v, 64'hCD_1234_5678);
    b_rd(12'h000, 1, v); chk("R2 counter0 untouched", v, 0);
    b_wr(12'h000, 64'hFFFF_FFFF_FFFF_FFFF, 1);
    b_rd(12'h000, 1, v); chk("R2 truncation to width", v, 64'hFF_FFFF_FFFF);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule